// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 16-bit byte virtual address into a 16-bit physical address. The three top address bits pick one of eight segments. Each segment has a register that holds the physical base of its page table in main memory. The next four bits index a two-byte page table entry (PTE) inside that table. The low nine bits are the offset within a 512-byte page.

A 16-entry direct-mapped translation cache keeps recent PTEs. It is indexed by the low four bits of the seven-bit virtual page number and tagged by the segment number. On a miss, a walker fetches the PTE as two byte reads over a simple request/acknowledge memory port. It then checks the entry, fills the cache and answers. The first write to a clean page writes the PTE's upper byte back to memory with the dirty flag set. Invalid entries and forbidden access kinds are reported as faults. A one-cycle flush input empties the cache when the address space changes.

The walker is a single FSM with these states:
- `WS_IDLE`: accepts a request and moves to `WS_LOOKUP`.
- `WS_LOOKUP`:
  - On a miss, goes to `WS_RD_LO`.
  - On a hit with a forbidden access, goes to `WS_RESP`.
  - On a hit with a write to a clean page, goes to `WS_WB`.
  - On any other hit, goes to `WS_RESP`.
- `WS_RD_LO`: on acknowledge, goes to `WS_RD_HI`.
- `WS_RD_HI`: on acknowledge, goes to `WS_CHECK`.
- `WS_CHECK`:
  - On an invalid entry or a forbidden access, goes to `WS_RESP`.
  - On a write to a clean page, fills the cache and goes to `WS_WB`.
  - Otherwise fills the cache and goes to `WS_RESP`.
- `WS_WB`: on acknowledge, updates the cache copy and goes to `WS_RESP`.
- `WS_RESP`: presents the result for one cycle and returns to `WS_IDLE`.

Top module: `seg_xlate`

## Requirements
- R1: After reset:
  - `req_ready` is 1.
  - `rsp_valid` and `mem_req` are 0.
  - Every cache entry is empty.
- R2: A cycle with `seg_we` high loads `seg_base_in` into the base register chosen by `seg_sel`. Later walks for that segment read from the new base.
- R3: On a cache miss, the PTE is read as two byte reads. The low byte comes first, at base + 2*page_index. The high byte follows at that address + 1.
- R4: The PTE layout is:
  - frame in bits [6:0]
  - valid in bit 7
  - read, write and execute permission in bits 8, 9 and 10
  - dirty in bit 11
  - aging in bits [15:12]

  A successful response gives `rsp_paddr` = {frame, vaddr[8:0]} and `rsp_fault` = 0.
- R5: A repeat access to a cached page (same vaddr[15:9]) completes with no memory transfer.
- R6: Two pages with the same vaddr[12:9] but different segments share one cache entry, so filling one evicts the other.
- R7: A PTE with valid = 0 gives `rsp_fault` = 1 and `rsp_paddr` = 0, and is not cached.
- R8: The access kind `req_kind` encodes read = 0, write = 1, execute = 2 and reserved = 3. Kinds 0 to 2 need permission bits 8 to 10 respectively; kind 3 is never allowed. A forbidden access gives `rsp_fault` = 2 and `rsp_paddr` = 0. On a miss, such a PTE is not cached.
- R9: A permitted write to a page whose dirty bit is 0 does one byte write of the PTE high byte to base + 2*page_index + 1. In that byte, bit 3 is set and the other bits are unchanged. The cached copy becomes dirty, so a later write to that page needs no memory transfer.
- R10: `tlb_flush` empties all cache entries in one cycle. The next access to any page walks again.
- R11: A write to a page whose dirty bit is already 1 does no write-back.
- R12: `mem_req` stays high with a constant `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack` is seen at a clock edge.
- R13: `rsp_valid` is a one-cycle pulse, once per accepted request. `req_ready` is 1 only while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tlb_flush | input | 1 | Empties the translation cache |
| seg_we | input | 1 | Segment base register write strobe |
| seg_sel | input | 3 | Segment register to write |
| seg_base_in | input | 16 | New page-table base |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 invalid page, 2 protection |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a byte write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Memory completes the transfer at this edge |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |

## Verification
The assertions assume the following about the inputs:
- `mem_ack` is raised only while `mem_req` is high.
- Segment bases are even.
- `seg_we` and `tlb_flush` are driven only while the walker is idle, so a walk never sees its base or its cache entry change underneath it.

The stimulus issues one request at a time, waits for each response, and touches the segment registers and the flush input only between requests. The memory model answers after a latency that varies from 0 to 2 cycles, so both the held-request path and the immediate-acknowledge path are exercised.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int PTE_W       = 16;
    localparam int PTE_VALID   = 7;
    localparam int PTE_PERM_LO = 8;
    localparam int PTE_DIRTY   = 11;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_LOOKUP,
        WS_RD_LO,
        WS_RD_HI,
        WS_CHECK,
        WS_WB,
        WS_RESP
    } walk_state_e;

    function automatic logic perm_ok(input logic [1:0] kind, input logic [2:0] perm);
        case (kind)
            ACC_READ:  perm_ok = perm[0];
            ACC_WRITE: perm_ok = perm[1];
            ACC_EXEC:  perm_ok = perm[2];
            default:   perm_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_base_regs.sv
module seg_base_regs #(
    parameter int AW    = 16,
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [AW-1:0]    wr_base,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [AW-1:0]    rd_base
);
    localparam int NSEG = 1 << SEG_W;

    logic [AW-1:0] base_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
            end else if (wr_en && wr_idx == SEG_W'(g)) begin
                base_q[g] <= wr_base;
            end
        end
    end

    assign rd_base = base_q[rd_idx];

    assert_seg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> base_q[$past(wr_idx)] == $past(wr_base));

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
    parameter int VPN_W = 7,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] vpn,
    output logic             hit,
    output logic [15:0]      hit_pte,
    input  logic             we,
    input  logic [15:0]      wr_pte
);
    localparam int TAG_W = VPN_W - IW;
    localparam int N     = 1 << IW;

    logic [N-1:0]     valid_q;
    logic [TAG_W-1:0] tag_q [N];
    logic [15:0]      pte_q [N];

    logic [IW-1:0]    idx;
    logic [TAG_W-1:0] tag;

    assign idx = vpn[IW-1:0];
    assign tag = vpn[VPN_W-1:IW];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid_q[g] <= 1'b0;
            end else if (we && idx == IW'(g)) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (we && idx == IW'(g)) begin
                tag_q[g] <= tag;
                pte_q[g] <= wr_pte;
            end
        end
    end

    assign hit     = valid_q[idx] && (tag_q[idx] == tag);
    assign hit_pte = pte_q[idx];

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import seg_xlate_pkg::*;
#(
    parameter int AW    = 16,
    parameter int SEG_W = 3,
    parameter int OFF_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [AW-1:0]          req_vaddr,
    input  logic [1:0]             req_kind,
    output logic                   rsp_valid,
    output logic [AW-1:0]          rsp_paddr,
    output logic [1:0]             rsp_fault,
    output logic [AW-OFF_W-1:0]    vpn,
    output logic [SEG_W-1:0]       seg_idx,
    input  logic [AW-1:0]          seg_base,
    input  logic                   tlb_hit,
    input  logic [PTE_W-1:0]       tlb_pte,
    output logic                   tlb_we,
    output logic [PTE_W-1:0]       tlb_wpte,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [7:0]             mem_wdata,
    input  logic                   mem_ack,
    input  logic [7:0]             mem_rdata
);
    localparam int VPN_W   = AW - OFF_W;
    localparam int PIDX_W  = VPN_W - SEG_W;
    localparam int FRAME_W = VPN_W;

    walk_state_e          state_q, state_d;
    logic [AW-1:0]        vaddr_q;
    logic [1:0]           kind_q;
    logic [PTE_W-1:0]     pte_q;
    fault_e               fault_q;

    logic [AW-1:0]        pt_addr;
    logic [PTE_W-1:0]     dirty_pte;
    logic                 xfer;
    logic                 hit_allowed;
    logic                 hit_needs_wb;
    logic                 walk_allowed;
    logic                 walk_needs_wb;

    assign vpn     = vaddr_q[AW-1:OFF_W];
    assign seg_idx = vaddr_q[AW-1 -: SEG_W];
    assign pt_addr = seg_base + {{(AW-PIDX_W-1){1'b0}}, vaddr_q[OFF_W +: PIDX_W], 1'b0};
    assign xfer    = mem_req && mem_ack;

    assign dirty_pte     = pte_q | (PTE_W'(1) << PTE_DIRTY);
    assign hit_allowed   = perm_ok(kind_q, tlb_pte[PTE_PERM_LO +: 3]);
    assign hit_needs_wb  = (kind_q == ACC_WRITE) && !tlb_pte[PTE_DIRTY];
    assign walk_allowed  = perm_ok(kind_q, pte_q[PTE_PERM_LO +: 3]);
    assign walk_needs_wb = (kind_q == ACC_WRITE) && !pte_q[PTE_DIRTY];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   if (req_valid) state_d = WS_LOOKUP;
            WS_LOOKUP: begin
                if (!tlb_hit)                         state_d = WS_RD_LO;
                else if (hit_allowed && hit_needs_wb) state_d = WS_WB;
                else                                  state_d = WS_RESP;
            end
            WS_RD_LO:  if (xfer) state_d = WS_RD_HI;
            WS_RD_HI:  if (xfer) state_d = WS_CHECK;
            WS_CHECK: begin
                if (pte_q[PTE_VALID] && walk_allowed && walk_needs_wb) state_d = WS_WB;
                else                                                   state_d = WS_RESP;
            end
            WS_WB:     if (xfer) state_d = WS_RESP;
            WS_RESP:   state_d = WS_IDLE;
            default:   state_d = WS_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            kind_q  <= '0;
            pte_q   <= '0;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state_q)
                WS_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    kind_q  <= req_kind;
                    fault_q <= FLT_NONE;
                end
                WS_LOOKUP: if (tlb_hit) begin
                    pte_q   <= tlb_pte;
                    fault_q <= hit_allowed ? FLT_NONE : FLT_PROT;
                end
                WS_RD_LO: if (xfer) pte_q[7:0]  <= mem_rdata;
                WS_RD_HI: if (xfer) pte_q[15:8] <= mem_rdata;
                WS_CHECK: begin
                    if (!pte_q[PTE_VALID]) fault_q <= FLT_PAGE;
                    else if (!walk_allowed) fault_q <= FLT_PROT;
                    else                    fault_q <= FLT_NONE;
                end
                WS_WB: if (xfer) pte_q <= dirty_pte;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tlb_we    = 1'b0;
        tlb_wpte  = pte_q;
        unique case (state_q)
            WS_IDLE:  req_ready = 1'b1;
            WS_RD_LO: begin
                mem_req  = 1'b1;
                mem_addr = pt_addr;
            end
            WS_RD_HI: begin
                mem_req  = 1'b1;
                mem_addr = pt_addr + AW'(1);
            end
            WS_CHECK: tlb_we = pte_q[PTE_VALID] && walk_allowed;
            WS_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pt_addr + AW'(1);
                mem_wdata = dirty_pte[15:8];
                tlb_we    = xfer;
                tlb_wpte  = dirty_pte;
            end
            WS_RESP:  rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rsp_fault = fault_q;
    assign rsp_paddr = (fault_q == FLT_NONE) ? {pte_q[FRAME_W-1:0], vaddr_q[OFF_W-1:0]} : '0;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_rsp_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_not_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rsp_valid) |-> !req_ready);

    assert_fill_valid_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_we |-> tlb_wpte[PTE_VALID]);

    assert_wb_sets_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[PTE_DIRTY-8]);

    assert_fault_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int AW     = 16,
    parameter int SEG_W  = 3,
    parameter int OFF_W  = 9,
    parameter int TLB_IW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tlb_flush,
    input  logic             seg_we,
    input  logic [SEG_W-1:0] seg_sel,
    input  logic [AW-1:0]    seg_base_in,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    output logic [AW-1:0]    rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic             mem_ack,
    input  logic [7:0]       mem_rdata
);
    localparam int VPN_W = AW - OFF_W;

    logic [VPN_W-1:0] vpn;
    logic [SEG_W-1:0] seg_idx;
    logic [AW-1:0]    seg_base;
    logic             tlb_hit;
    logic [PTE_W-1:0] tlb_pte;
    logic             tlb_we;
    logic [PTE_W-1:0] tlb_wpte;

    seg_base_regs #(.AW(AW), .SEG_W(SEG_W)) u_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_we),
        .wr_idx  (seg_sel),
        .wr_base (seg_base_in),
        .rd_idx  (seg_idx),
        .rd_base (seg_base)
    );

    xlate_tlb #(.VPN_W(VPN_W), .IW(TLB_IW)) u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tlb_flush),
        .vpn     (vpn),
        .hit     (tlb_hit),
        .hit_pte (tlb_pte),
        .we      (tlb_we),
        .wr_pte  (tlb_wpte)
    );

    xlate_walker #(.AW(AW), .SEG_W(SEG_W), .OFF_W(OFF_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_vaddr (req_vaddr),
        .req_kind  (req_kind),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_fault (rsp_fault),
        .vpn       (vpn),
        .seg_idx   (seg_idx),
        .seg_base  (seg_base),
        .tlb_hit   (tlb_hit),
        .tlb_pte   (tlb_pte),
        .tlb_we    (tlb_we),
        .tlb_wpte  (tlb_wpte),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tlb_flush = 1'b0;
    logic        seg_we = 1'b0;
    logic [2:0]  seg_sel = '0;
    logic [15:0] seg_base_in = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    always #4 clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .tlb_flush(tlb_flush),
        .seg_we(seg_we), .seg_sel(seg_sel), .seg_base_in(seg_base_in),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // memory model
    logic [7:0]  mem [0:4095];
    logic [16:0] logq [$];
    int          ops = 0;
    int          wait_cnt = 0;
    bit          pending = 1'b0;
    logic [15:0] held_addr = '0;
    int          unstable = 0;

    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (rst_n && mem_req) begin
            if (!pending) begin
                pending   = 1'b1;
                held_addr = mem_addr;
                wait_cnt  = ops % 3;
            end else if (mem_addr != held_addr) begin
                unstable++;
            end
            if (wait_cnt == 0) begin
                if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[11:0]];
                logq.push_back({mem_we, mem_addr});
                mem_ack = 1'b1;
                ops++;
                pending = 1'b0;
            end else begin
                wait_cnt--;
            end
        end
    end

    // scoreboard
    typedef struct {
        logic [15:0] paddr;
        logic [1:0]  fault;
        int          nops;
        int          ops0;
        string       req;
    } exp_t;
    exp_t sbq [$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R13", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(rsp_paddr == e.paddr, e.req, "paddr", rsp_paddr, e.paddr);
                check(rsp_fault == e.fault, e.req, "fault", rsp_fault, e.fault);
                check(ops - e.ops0 == e.nops, e.req, "memory transfers", ops - e.ops0, e.nops);
            end
        end
    end

    function automatic logic [15:0] mkpte(logic [6:0] frame, logic v, logic [2:0] perm,
                                          logic dirty, logic [3:0] aging);
        return {aging, dirty, perm, v, frame};
    endfunction

    task automatic put_pte(int addr, logic [15:0] pte);
        mem[addr]     = pte[7:0];
        mem[addr + 1] = pte[15:8];
    endtask

    task automatic access(logic [15:0] va, logic [1:0] k, logic [15:0] pa,
                          logic [1:0] f, int n, string req);
        exp_t e;
        @(negedge clk);
        logq.delete();
        e.paddr = pa; e.fault = f; e.nops = n; e.ops0 = ops; e.req = req;
        sbq.push_back(e);
        req_valid = 1'b1;
        req_vaddr = va;
        req_kind  = k;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R13", "ready while busy", req_ready, 0);
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_seg(logic [2:0] s, logic [15:0] b);
        @(negedge clk);
        seg_we = 1'b1; seg_sel = s; seg_base_in = b;
        @(negedge clk);
        seg_we = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        tlb_flush = 1'b1;
        @(negedge clk);
        tlb_flush = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        put_pte(16'h0106, mkpte(7'h55, 1'b1, 3'b001, 1'b0, 4'h0));
        put_pte(16'h0206, mkpte(7'h12, 1'b1, 3'b111, 1'b1, 4'h5));
        put_pte(16'h0A00, mkpte(7'h7F, 1'b1, 3'b011, 1'b0, 4'hA));
        put_pte(16'h0102, mkpte(7'h01, 1'b1, 3'b100, 1'b0, 4'h0));
        put_pte(16'h0306, mkpte(7'h33, 1'b1, 3'b001, 1'b0, 4'h0));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        check(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);

        set_seg(3'd0, 16'h0100);
        set_seg(3'd1, 16'h0200);
        set_seg(3'd5, 16'h0A00);

        // R1 empty cache: first access walks; R3 read order; R4 address compose
        access(16'h07AB, 2'd0, 16'hABAB, 2'd0, 2, "R4");
        check(logq.size() == 2, "R3", "transfer count", logq.size(), 2);
        if (logq.size() == 2) begin
            check(logq[0] == 17'h00106, "R3", "first read", logq[0], 17'h00106);
            check(logq[1] == 17'h00107, "R3", "second read", logq[1], 17'h00107);
        end

        // R5 hit
        access(16'h0600, 2'd0, 16'hAA00, 2'd0, 0, "R5");
        // R8 forbidden write on a hit
        access(16'h07AB, 2'd1, 16'h0000, 2'd2, 0, "R8");

        // R6 conflicting pages share index 3
        access(16'h2610, 2'd0, 16'h2410, 2'd0, 2, "R6");
        access(16'h0600, 2'd0, 16'hAA00, 2'd0, 2, "R6");

        // R9 dirty write-back
        access(16'hA004, 2'd1, 16'hFE04, 2'd0, 3, "R9");
        check(mem[12'hA01] == 8'hAB, "R9", "high byte after write-back", mem[12'hA01], 8'hAB);
        check(mem[12'hA00] == 8'hFF, "R9", "low byte untouched", mem[12'hA00], 8'hFF);
        if (logq.size() == 3)
            check(logq[2] == 17'h10A01, "R9", "write-back address", logq[2], 17'h10A01);
        access(16'hA1F0, 2'd1, 16'hFFF0, 2'd0, 0, "R9");

        // R11 write to already dirty page
        access(16'h2610, 2'd1, 16'h2410, 2'd0, 2, "R11");

        // R7 invalid entry, not cached
        access(16'h0A00, 2'd0, 16'h0000, 2'd1, 2, "R7");
        access(16'h0A00, 2'd0, 16'h0000, 2'd1, 2, "R7");

        // R8 execute allowed on hit, reserved kind refused
        access(16'h2610, 2'd2, 16'h2410, 2'd0, 0, "R8");
        access(16'h2610, 2'd3, 16'h0000, 2'd2, 0, "R8");
        // R8 forbidden on a miss is not cached
        access(16'h0210, 2'd0, 16'h0000, 2'd2, 2, "R8");
        access(16'h0210, 2'd0, 16'h0000, 2'd2, 2, "R8");
        access(16'h0210, 2'd2, 16'h0210, 2'd0, 2, "R8");

        // R10 flush forces a new walk
        flush();
        access(16'h2610, 2'd0, 16'h2410, 2'd0, 2, "R10");

        // R2 reprogrammed base
        set_seg(3'd1, 16'h0300);
        flush();
        access(16'h2610, 2'd0, 16'h6610, 2'd0, 2, "R2");
        if (logq.size() >= 1)
            check(logq[0] == 17'h00306, "R2", "walk uses new base", logq[0], 17'h00306);

        // R12 address held while waiting
        check(unstable == 0, "R12", "address changes while waiting", unstable, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule